// File: doc/BRIEF.md
# Size-Scaled DMA Completion Watchdog

This block supervises a single DMA transfer from launch to its outcome. The transfer length in bytes arrives together with a one-cycle start pulse. From that length the block derives a time budget in milliseconds: the length is converted to whole megabytes, rounded up, and each megabyte earns 333 ms of budget. A floor of 1000 ms applies whenever the scaled figure would be smaller. It then counts pulses of a 1 ms tick input while it waits for the transfer-complete status or an engine error flag.

Exactly one outcome is reported per transfer, as a one-cycle pulse on `done`, `error` or `timeout`. On success the block also emits `tc_clear`, a write-one-to-clear strobe for the transfer-complete status bit. A `cleanup` pulse, which tells the surrounding logic to release its DMA setup, accompanies success and error but not a timeout. An error flag that is already raised when supervision begins ends the transfer at once, without waiting.

States: `ST_IDLE` (waits for `start`), `ST_CHECK` (one cycle, samples the error flag before waiting), `ST_WAIT` (counts ticks), and the one-cycle result states `ST_DONE`, `ST_FAIL`, `ST_EXPIRE`. Transitions: IDLE→CHECK on `start`; CHECK→FAIL when `adma_err` is high, else CHECK→WAIT; WAIT→DONE on `xfer_done`, otherwise WAIT→FAIL on `adma_err`, otherwise WAIT→EXPIRE when the tick count exceeds the budget; DONE, FAIL and EXPIRE each return to IDLE after one cycle.

Top module: `dma_done_watchdog`

## Requirements
- R1: After reset `done`, `error`, `timeout`, `tc_clear` and `cleanup` are low, and they stay low while no `start` is given, even with `tick_ms` active.
- R2: The budget is ceil(`size_bytes` / 2^20) × 333 ms; a size one byte above a megabyte multiple earns one more megabyte than the multiple itself.
- R3: When the scaled budget is below 1000 ms (including a size of zero), the budget is 1000 ms.
- R4: The comparison is strictly greater-than: with `tick_ms` high every cycle and counting the edge that samples `start` as edge 1, `timeout` is high after edge budget+4 and no outcome exists after edge budget+3.
- R5: If `adma_err` is high when supervision begins, `error` and `cleanup` are high after edge 2, with `tc_clear` low.
- R6: When `xfer_done` is high at an edge in the waiting state, `done`, `tc_clear` and `cleanup` are high after that edge.
- R7: When `adma_err` rises during waiting (and `xfer_done` is low), `error` and `cleanup` are high after that edge, with `tc_clear` low.
- R8: Completion wins: `xfer_done` at the same edge as the timeout condition or as `adma_err` yields `done`.
- R9: A timeout raises neither `cleanup` nor `tc_clear`.
- R10: At most one of `done`, `error`, `timeout` is high in any cycle; each result lasts exactly one cycle, after which all outputs are low and a new `start` is accepted.
- R11: A `start` pulse while a transfer is supervised is ignored; neither the budget nor the elapsed count changes.
- R12: Only `tick_ms` pulses advance elapsed time; with `tick_ms` low no timeout occurs however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins supervision |
| size_bytes | input | SIZE_W (32) | Transfer length in bytes, sampled with `start` |
| tick_ms | input | 1 | One-cycle pulse per elapsed millisecond |
| xfer_done | input | 1 | Transfer-complete status |
| adma_err | input | 1 | DMA engine error status |
| done | output | 1 | Success pulse |
| error | output | 1 | I/O error pulse |
| timeout | output | 1 | Budget exceeded pulse |
| tc_clear | output | 1 | Write-one-to-clear strobe for the transfer-complete status |
| cleanup | output | 1 | Release-DMA-setup pulse on success or error |

## Verification
Completion can coincide with the expiry of the budget, and completion can coincide with a mid-transfer error. The first is provoked by raising `xfer_done` so that it is first sampled exactly at edge budget+4, the edge where the tick count first exceeds the budget, and one edge earlier as a control; the second by raising `xfer_done` and `adma_err` for the same edge. Both are judged by requiring `done` with `tc_clear` and `cleanup` at that exact edge and no `timeout` or `error`.

// File: rtl/dwd_pkg.sv
package dwd_pkg;

    parameter int DWD_SIZE_W    = 32;
    parameter int DWD_MB_SHIFT  = 20;
    parameter int DWD_MS_PER_MB = 333;
    parameter int DWD_FLOOR_MS  = 1000;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_DONE   = 3'd3,
        ST_FAIL   = 3'd4,
        ST_EXPIRE = 3'd5
    } dwd_state_t;

endpackage

// File: rtl/dwd_limit.sv
module dwd_limit #(
    parameter int SIZE_W    = 32,
    parameter int MB_SHIFT  = 20,
    parameter int MS_PER_MB = 333,
    parameter int FLOOR_MS  = 1000,
    parameter int LIM_W     = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size_bytes,
    output logic [LIM_W-1:0]  limit_ms
);

    localparam int MB_W = SIZE_W - MB_SHIFT + 1;

    logic [MB_W-1:0]  mb_ceil;
    logic [LIM_W-1:0] scaled;
    logic [LIM_W-1:0] budget;

    // whole megabytes plus one for any remainder
    always_comb begin
        mb_ceil = MB_W'(size_bytes >> MB_SHIFT) + MB_W'(|size_bytes[MB_SHIFT-1:0]);
        scaled  = LIM_W'(mb_ceil) * LIM_W'(MS_PER_MB);
        budget  = (scaled < LIM_W'(FLOOR_MS)) ? LIM_W'(FLOOR_MS) : scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_ms <= LIM_W'(FLOOR_MS);
        end else if (load) begin
            limit_ms <= budget;
        end
    end

endmodule

// File: rtl/dwd_tick_count.sv
module dwd_tick_count #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    output logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (clr) begin
            elapsed <= '0;
        end else if (en && tick && (elapsed != TOP)) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dwd_fsm.sv
module dwd_fsm
    import dwd_pkg::*;
#(
    parameter int LIM_W = 22,
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             xfer_done,
    input  logic             adma_err,
    input  logic [CNT_W-1:0] elapsed,
    input  logic [LIM_W-1:0] limit_ms,
    output logic             load,
    output logic             cnt_clr,
    output logic             cnt_en,
    output logic             done,
    output logic             error,
    output logic             timeout,
    output logic             tc_clear,
    output logic             cleanup
);

    dwd_state_t state;
    dwd_state_t nxt;
    logic       expired;

    assign expired = elapsed > CNT_W'(limit_ms);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = ST_CHECK;
            end
            ST_CHECK: begin
                nxt = adma_err ? ST_FAIL : ST_WAIT;
            end
            ST_WAIT: begin
                if (xfer_done)     nxt = ST_DONE;
                else if (adma_err) nxt = ST_FAIL;
                else if (expired)  nxt = ST_EXPIRE;
            end
            ST_DONE, ST_FAIL, ST_EXPIRE: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        done     = 1'b0;
        error    = 1'b0;
        timeout  = 1'b0;
        tc_clear = 1'b0;
        cleanup  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load    = start;
                cnt_clr = start;
            end
            ST_CHECK: ;
            ST_WAIT: begin
                cnt_en = 1'b1;
            end
            ST_DONE: begin
                done     = 1'b1;
                tc_clear = 1'b1;
                cleanup  = 1'b1;
            end
            ST_FAIL: begin
                error   = 1'b1;
                cleanup = 1'b1;
            end
            ST_EXPIRE: begin
                timeout = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_done_watchdog.sv
module dma_done_watchdog
    import dwd_pkg::*;
#(
    parameter int SIZE_W    = DWD_SIZE_W,
    parameter int MB_SHIFT  = DWD_MB_SHIFT,
    parameter int MS_PER_MB = DWD_MS_PER_MB,
    parameter int FLOOR_MS  = DWD_FLOOR_MS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] size_bytes,
    input  logic              tick_ms,
    input  logic              xfer_done,
    input  logic              adma_err,
    output logic              done,
    output logic              error,
    output logic              timeout,
    output logic              tc_clear,
    output logic              cleanup
);

    localparam int MB_W  = SIZE_W - MB_SHIFT + 1;
    localparam int LIM_W = MB_W + $clog2(MS_PER_MB + 1);
    localparam int CNT_W = LIM_W + 1;

    logic             load;
    logic             cnt_clr;
    logic             cnt_en;
    logic [LIM_W-1:0] limit_ms;
    logic [CNT_W-1:0] elapsed;

    dwd_limit #(
        .SIZE_W    (SIZE_W),
        .MB_SHIFT  (MB_SHIFT),
        .MS_PER_MB (MS_PER_MB),
        .FLOOR_MS  (FLOOR_MS),
        .LIM_W     (LIM_W)
    ) u_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .size_bytes (size_bytes),
        .limit_ms   (limit_ms)
    );

    dwd_tick_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .en      (cnt_en),
        .tick    (tick_ms),
        .elapsed (elapsed)
    );

    dwd_fsm #(
        .LIM_W (LIM_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .xfer_done (xfer_done),
        .adma_err  (adma_err),
        .elapsed   (elapsed),
        .limit_ms  (limit_ms),
        .load      (load),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en),
        .done      (done),
        .error     (error),
        .timeout   (timeout),
        .tc_clear  (tc_clear),
        .cleanup   (cleanup)
    );

endmodule

// File: rtl/dwd_checker.sv
module dwd_checker (
    input logic clk,
    input logic rst_n,
    input logic xfer_done,
    input logic adma_err,
    input logic done,
    input logic error,
    input logic timeout,
    input logic tc_clear,
    input logic cleanup
);

    // R6
    done_follows_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(xfer_done));

    // R7
    error_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(adma_err));

    // R8
    completion_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !$past(xfer_done) && !$past(adma_err));

    // R10
    single_cycle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error || timeout) |=> !(done || error || timeout));

    // R9
    cleanup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cleanup |-> ($past(xfer_done) || $past(adma_err)));

    // R6
    clear_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clear |-> $past(xfer_done));

endmodule

bind dma_done_watchdog dwd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_done (xfer_done),
    .adma_err  (adma_err),
    .done      (done),
    .error     (error),
    .timeout   (timeout),
    .tc_clear  (tc_clear),
    .cleanup   (cleanup)
);

// File: tb/tb_dma_done_watchdog.sv
`timescale 1ns/1ps
module tb_dma_done_watchdog;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] size_bytes;
    logic        tick_ms;
    logic        xfer_done;
    logic        adma_err;
    logic        done, error, timeout, tc_clear, cleanup;

    int vectors     = 0;
    int miscompares = 0;
    bit finished    = 0;

    always #4 clk = ~clk;

    dma_done_watchdog dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .size_bytes (size_bytes),
        .tick_ms    (tick_ms),
        .xfer_done  (xfer_done),
        .adma_err   (adma_err),
        .done       (done),
        .error      (error),
        .timeout    (timeout),
        .tc_clear   (tc_clear),
        .cleanup    (cleanup)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint budget_of(input longint sz);
        longint mb = (sz + 64'd1048575) >> 20;
        longint l  = mb * 333;
        return (l < 1000) ? 1000 : l;
    endfunction

    // kind: 0 none, 1 done, 2 error, 3 timeout
    task automatic run(input longint sz, input bit err0, input int done_at,
                       input int err_at, input int maxc, input int tick_mode,
                       input int restart_at, output int kind, output int cyc,
                       output bit tcv, output bit clv);
        kind = 0; cyc = 0; tcv = 0; clv = 0;
        @(negedge clk);
        start      = 1'b1;
        size_bytes = 32'(sz);
        adma_err   = err0;
        xfer_done  = 1'b0;
        tick_ms    = (tick_mode == 0);
        for (int c = 1; c <= maxc; c++) begin
            @(negedge clk);
            start = (c == restart_at);
            if (start) size_bytes = 32'h00F0_0000;
            chk((int'(done) + int'(error) + int'(timeout)) <= 1, "R10",
                "results exclusive", int'(done) + int'(error) + int'(timeout), 1);
            if (done || error || timeout) begin
                kind = done ? 1 : (error ? 2 : 3);
                cyc  = c;
                tcv  = tc_clear;
                clv  = cleanup;
                break;
            end
            xfer_done = (done_at > 0) && (c + 1 >= done_at);
            adma_err  = err0 || ((err_at > 0) && (c + 1 >= err_at));
            case (tick_mode)
                0:       tick_ms = 1'b1;
                1:       tick_ms = 1'b0;
                default: tick_ms = 1'($urandom % 2);
            endcase
        end
        start = 1'b0; xfer_done = 1'b0; adma_err = 1'b0; tick_ms = 1'b0;
        @(negedge clk);
        chk(!(done || error || timeout || tc_clear || cleanup), "R10",
            "outputs low after result", int'({done, error, timeout, tc_clear, cleanup}), 0);
    endtask

    task automatic expect_result(input string req, input int kind, input int cyc,
                                 input bit tcv, input bit clv, input int ekind,
                                 input int ecyc);
        chk(kind == ekind, req, "outcome kind", kind, ekind);
        chk(cyc == ecyc, req, "outcome edge", cyc, ecyc);
        chk(tcv == (ekind == 1), req, "tc_clear", tcv, (ekind == 1));
        chk(clv == (ekind == 1 || ekind == 2), req, "cleanup", clv, (ekind == 1 || ekind == 2));
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int kind, cyc, lim, dat;
        bit tcv, clv;
        int unsigned seed_draw;
        longint sz;

        seed_draw = $urandom(32'd20240611);
        rst_n = 1'b0; start = 1'b0; size_bytes = '0;
        tick_ms = 1'b0; xfer_done = 1'b0; adma_err = 1'b0;
        repeat (3) @(negedge clk);
        chk(!(done || error || timeout || tc_clear || cleanup), "R1",
            "outputs in reset", int'({done, error, timeout, tc_clear, cleanup}), 0);
        rst_n = 1'b1;
        tick_ms = 1'b1;
        begin
            bit any = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (done || error || timeout || tc_clear || cleanup) any = 1;
            end
            chk(!any, "R1", "no output without start", any, 0);
        end
        tick_ms = 1'b0;

        // R3: zero size takes the floor
        run(0, 0, 0, 0, 1100, 0, 0, kind, cyc, tcv, clv);
        expect_result("R3", kind, cyc, tcv, clv, 3, 1004);
        // R3: three megabytes scale below the floor
        run(64'd3 << 20, 0, 0, 0, 1100, 0, 0, kind, cyc, tcv, clv);
        expect_result("R3", kind, cyc, tcv, clv, 3, 1004);
        // R2: exact multiple, one byte short, one byte over
        run(64'd4 << 20, 0, 0, 0, 1400, 0, 0, kind, cyc, tcv, clv);
        expect_result("R2", kind, cyc, tcv, clv, 3, 1336);
        run((64'd4 << 20) - 1, 0, 0, 0, 1400, 0, 0, kind, cyc, tcv, clv);
        expect_result("R2", kind, cyc, tcv, clv, 3, 1336);
        run((64'd4 << 20) + 1, 0, 0, 0, 1700, 0, 0, kind, cyc, tcv, clv);
        expect_result("R2", kind, cyc, tcv, clv, 3, 1669);
        // R4: completion one edge before expiry; R9 already checked above
        run(0, 0, 1003, 0, 1100, 0, 0, kind, cyc, tcv, clv);
        expect_result("R4", kind, cyc, tcv, clv, 1, 1003);
        // R8: completion at the expiry edge
        run(0, 0, 1004, 0, 1100, 0, 0, kind, cyc, tcv, clv);
        expect_result("R8", kind, cyc, tcv, clv, 1, 1004);
        // R5: error already raised
        run(64'd1 << 20, 1, 0, 0, 50, 0, 0, kind, cyc, tcv, clv);
        expect_result("R5", kind, cyc, tcv, clv, 2, 2);
        // R7: error while waiting
        run(64'd1 << 20, 0, 0, 50, 200, 0, 0, kind, cyc, tcv, clv);
        expect_result("R7", kind, cyc, tcv, clv, 2, 50);
        // R8: completion and error together
        run(64'd1 << 20, 0, 60, 60, 200, 0, 0, kind, cyc, tcv, clv);
        expect_result("R8", kind, cyc, tcv, clv, 1, 60);
        // R6: early completion
        run(64'd2 << 20, 0, 3, 0, 50, 0, 0, kind, cyc, tcv, clv);
        expect_result("R6", kind, cyc, tcv, clv, 1, 3);
        // R11: second start while waiting is ignored
        run(0, 0, 0, 0, 1100, 0, 10, kind, cyc, tcv, clv);
        expect_result("R11", kind, cyc, tcv, clv, 3, 1004);
        // R12: no ticks, no timeout
        run(0, 0, 2500, 0, 3000, 1, 0, kind, cyc, tcv, clv);
        expect_result("R12", kind, cyc, tcv, clv, 1, 2500);

        // random sizes, completion anywhere around the budget (R2 R4 R6 R8)
        for (int i = 0; i < 12; i++) begin
            sz  = longint'($urandom % (32'd6 << 20));
            lim = int'(budget_of(sz));
            dat = 3 + int'($urandom % 32'(lim + 4));
            run(sz, 0, dat, 0, lim + 10, 0, 0, kind, cyc, tcv, clv);
            if (dat <= lim + 4) expect_result("R6", kind, cyc, tcv, clv, 1, dat);
            else                expect_result("R4", kind, cyc, tcv, clv, 3, lim + 4);
        end
        // random tick gaps with early completion (R12)
        for (int i = 0; i < 6; i++) begin
            sz  = longint'($urandom % (32'd6 << 20));
            dat = 3 + int'($urandom % 900);
            run(sz, 0, dat, 0, 1000, 2, 0, kind, cyc, tcv, clv);
            expect_result("R12", kind, cyc, tcv, clv, 1, dat);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule